// File: doc/BRIEF.md
# Recirculating Escape-Time Iteration Ring

The block computes escape-time iteration counts for points of the complex plane. A point enters with its constant c = (cr, ci) and a pixel tag. It then travels around a closed ring of registers. Each lap applies one step of z = z² + c, starting from z = 0, and tests whether the point has diverged.

The number of laps is decided per point at run time. Fast-escaping points leave early and free their ring slot. A waiting input point takes that freed slot in the same cycle. Results therefore leave out of order, and each result carries the tag of its point so a downstream stage can put it back in place.

Both edges use valid/ready handshakes. There is exactly one decision point in the ring, so at most one point can leave per cycle. A finished point that cannot leave stays parked in its slot. It goes around again unchanged and offers itself again on its next lap.

Top module: `mandel_ring`

## Requirements
- R1: After reset every ring slot is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: Arithmetic on the components uses signed 18-bit values with 15 fraction bits.
  - Each square is the full product shifted right arithmetically by 15. The cross term 2·zr·zi is the product of zr and zi shifted right by 14.
  - The new zr is the squared zr minus the squared zi plus cr. The new zi is the cross term plus ci. Both are saturated to the 18-bit range.
  - The reported count is the number of updates applied before the point stopped. For example, c = 0 always runs to the limit.
- R3: The divergence test is strict: a point stops when the sum of its two squares is greater than 4.0 (131072 in the raw format). With a limit of 30, c = (2.0, 0) stops with count 2, and c = (-2.0, 0) runs to count 30.
- R4: A point also stops when its count equals `max_iter`. With `max_iter` = 0 every point returns count 0. No result ever carries a count above `max_iter`.
- R5: Every result carries the tag its point entered with, and results may leave in a different order from entry. A quickly diverging point sent after a slow one is returned first.
- R6: Input is accepted on consecutive cycles with no idle cycle. From an empty ring, DEPTH points are taken on DEPTH back-to-back cycles, and each lands in the entry slot with count 0.
- R7: In one cycle, a finished point can leave through the output while a new point is accepted into the slot it frees.
- R8: When `out_ready` is low, finished points stay in the ring with the same tag and count and are offered again on later laps. None is lost or duplicated.
- R9: The ring holds at most DEPTH points. `in_ready` is 0 when the returning slot is occupied and is not leaving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_iter | input | 10 | Iteration limit; hold steady while points are in flight |
| in_valid | input | 1 | Input point offered |
| in_ready | output | 1 | Ring can take the offered point this cycle |
| in_cr | input | 18 | Real part of c, signed, 15 fraction bits |
| in_ci | input | 18 | Imaginary part of c, signed, 15 fraction bits |
| in_tag | input | 8 | Pixel tag of the input point |
| out_valid | output | 1 | A finished point is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_tag | output | 8 | Tag of the finished point |
| out_count | output | 10 | Iterations applied to the finished point |

## Verification
Retiring a finished point and admitting a new one both depend on the single slot returning to the ring entry, so the two can fall in the same cycle. A long stream of mixed fast and slow points is sent with the output always ready and the input always offered. This keeps slots finishing while inputs wait. The bench counts the cycles in which an output handshake and an input handshake happen together. It also checks, through the tag-indexed scoreboard, that the refilled slot's point and the departing point each come back exactly once with the count predicted by a bit-exact model of the fixed-point step.

// File: rtl/mandel_pkg.sv
package mandel_pkg;

    localparam int DW    = 18;       // operand width of every multiply
    localparam int FW    = 15;       // fraction bits
    localparam int PW    = 2 * DW;   // full product width
    localparam int TAG_W = 8;
    localparam int CNT_W = 10;

    typedef logic signed [DW-1:0] fx_t;
    typedef logic signed [PW-1:0] wide_t;

    // one point held in a ring slot
    typedef struct packed {
        logic             valid;
        logic             fin;     // finished and parked, waiting for output
        fx_t              zr;
        fx_t              zi;
        fx_t              cr;
        fx_t              ci;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    // a slot after the multiply stage, with its products attached
    typedef struct packed {
        slot_t s;
        wide_t rr;    // zr^2, scaled back to FW fraction bits
        wide_t ii;    // zi^2, scaled back
        wide_t ri2;   // 2*zr*zi, scaled back
    } stage_t;

    typedef struct packed {
        slot_t  s0;
        stage_t s1;
    } ring_regs_t;

endpackage

// File: rtl/mandel_mult.sv
module mandel_mult
    import mandel_pkg::*;
(
    input  slot_t  slot_i,
    output stage_t prod_o
);

    function automatic wide_t mul18(input fx_t a, input fx_t b);
        wide_t ea;
        wide_t eb;
        ea = PW'(a);
        eb = PW'(b);
        return ea * eb;
    endfunction

    wide_t p_rr;
    wide_t p_ii;
    wide_t p_ri;

    always_comb begin
        p_rr = mul18(slot_i.zr, slot_i.zr);
        p_ii = mul18(slot_i.zi, slot_i.zi);
        p_ri = mul18(slot_i.zr, slot_i.zi);

        prod_o.s   = slot_i;
        prod_o.rr  = p_rr >>> FW;
        prod_o.ii  = p_ii >>> FW;
        prod_o.ri2 = p_ri >>> (FW - 1);
    end

endmodule

// File: rtl/mandel_delay.sv
module mandel_delay
    import mandel_pkg::*;
#(
    parameter int N = 6
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t d_i,
    output stage_t q_o
);

    generate
        if (N == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_pipe
            stage_t pipe_d [N];
            stage_t pipe_q [N];

            always_comb begin
                pipe_d[0] = d_i;
                for (int i = 1; i < N; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < N; i++) begin
                    if (!rst_n) begin
                        pipe_q[i] <= '0;
                    end else begin
                        pipe_q[i] <= pipe_d[i];
                    end
                end
            end

            assign q_o = pipe_q[N-1];
        end
    endgenerate

endmodule

// File: rtl/mandel_step.sv
module mandel_step
    import mandel_pkg::*;
(
    input  stage_t           ret_i,
    input  logic [CNT_W-1:0] max_iter,
    input  logic             in_valid,
    input  fx_t              in_cr,
    input  fx_t              in_ci,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [CNT_W-1:0] out_count,
    output slot_t            next_o
);

    typedef logic signed [PW:0] acc_t;

    localparam acc_t ESC_LIM = acc_t'(4 <<< FW);
    localparam acc_t SAT_HI  = acc_t'((2 ** (DW - 1)) - 1);
    localparam acc_t SAT_LO  = -SAT_HI - acc_t'(1);

    function automatic acc_t ext_fx(input fx_t v);
        return acc_t'(v);
    endfunction

    function automatic acc_t ext_w(input wide_t v);
        return acc_t'(v);
    endfunction

    function automatic fx_t clamp(input acc_t v);
        fx_t r;
        if (v > SAT_HI) begin
            r = fx_t'(SAT_HI);
        end else if (v < SAT_LO) begin
            r = fx_t'(SAT_LO);
        end else begin
            r = v[DW-1:0];
        end
        return r;
    endfunction

    acc_t  mag;
    acc_t  zr_sum;
    acc_t  zi_sum;
    logic  escaped;
    logic  at_limit;
    logic  done_now;
    logic  leaving;
    logic  slot_free;
    slot_t fresh;
    slot_t stepped;
    slot_t parked;

    always_comb begin
        mag      = ext_w(ret_i.rr) + ext_w(ret_i.ii);
        escaped  = mag > ESC_LIM;
        at_limit = ret_i.s.cnt >= max_iter;
        done_now = ret_i.s.valid && (ret_i.s.fin || escaped || at_limit);

        leaving   = done_now && out_ready;
        slot_free = !ret_i.s.valid || leaving;

        zr_sum = ext_w(ret_i.rr) - ext_w(ret_i.ii) + ext_fx(ret_i.s.cr);
        zi_sum = ext_w(ret_i.ri2) + ext_fx(ret_i.s.ci);

        fresh       = '0;
        fresh.valid = in_valid;
        fresh.cr    = in_cr;
        fresh.ci    = in_ci;
        fresh.tag   = in_tag;

        stepped     = ret_i.s;
        stepped.zr  = clamp(zr_sum);
        stepped.zi  = clamp(zi_sum);
        stepped.cnt = ret_i.s.cnt + CNT_W'(1);

        parked      = ret_i.s;
        parked.fin  = 1'b1;

        if (slot_free) begin
            next_o = fresh;
        end else if (done_now) begin
            next_o = parked;
        end else begin
            next_o = stepped;
        end

        in_ready  = slot_free;
        out_valid = done_now;
        out_tag   = ret_i.s.tag;
        out_count = ret_i.s.cnt;
    end

endmodule

// File: rtl/mandel_ring.sv
module mandel_ring
    import mandel_pkg::*;
#(
    parameter int DEPTH = 8    // ring length in slots, at least 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] max_iter,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_cr,
    input  logic [DW-1:0]    in_ci,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TAG_W-1:0] out_tag,
    output logic [CNT_W-1:0] out_count
);

    localparam int TAIL = DEPTH - 2;

    ring_regs_t r_d;
    ring_regs_t r_q;
    stage_t     mult_out;
    stage_t     ret;
    slot_t      entry_next;

    // observation points for the bound checker
    logic             s0_valid;
    logic             s0_fin;
    logic [TAG_W-1:0] s0_tag;
    logic [CNT_W-1:0] s0_cnt;

    mandel_mult u_mult (
        .slot_i (r_q.s0),
        .prod_o (mult_out)
    );

    mandel_delay #(.N(TAIL)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (r_q.s1),
        .q_o   (ret)
    );

    mandel_step u_step (
        .ret_i     (ret),
        .max_iter  (max_iter),
        .in_valid  (in_valid),
        .in_cr     (fx_t'(in_cr)),
        .in_ci     (fx_t'(in_ci)),
        .in_tag    (in_tag),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_count (out_count),
        .next_o    (entry_next)
    );

    always_comb begin
        r_d    = r_q;
        r_d.s0 = entry_next;
        r_d.s1 = mult_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign s0_valid = r_q.s0.valid;
    assign s0_fin   = r_q.s0.fin;
    assign s0_tag   = r_q.s0.tag;
    assign s0_cnt   = r_q.s0.cnt;

endmodule

module mandel_ring_chk
    import mandel_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] max_iter,
    input logic             in_valid,
    input logic             in_ready,
    input logic [TAG_W-1:0] in_tag,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TAG_W-1:0] out_tag,
    input logic [CNT_W-1:0] out_count,
    input logic             s0_valid,
    input logic             s0_fin,
    input logic [TAG_W-1:0] s0_tag,
    input logic [CNT_W-1:0] s0_cnt
);

    localparam int OW = $clog2(DEPTH + 1) + 1;

    logic [OW-1:0] occ_q;
    logic          in_fire;
    logic          out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OW'(in_fire) - OW'(out_fire);
        end
    end

    // R9
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(DEPTH));

    // R1
    no_phantom_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ_q != '0));

    // R4
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count <= max_iter));

    // R6
    admit_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> (s0_valid && !s0_fin && s0_cnt == '0 && s0_tag == $past(in_tag)));

    // R8
    park_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (s0_valid && s0_fin && s0_tag == $past(out_tag) && s0_cnt == $past(out_count)));

endmodule

bind mandel_ring mandel_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .max_iter  (max_iter),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_count (out_count),
    .s0_valid  (s0_valid),
    .s0_fin    (s0_fin),
    .s0_tag    (s0_tag),
    .s0_cnt    (s0_cnt)
);

// File: tb/mandel_ring_test.sv
module mandel_ring_test;
    import mandel_pkg::*;

    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] max_iter;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [DW-1:0]    in_cr = '0;
    logic [DW-1:0]    in_ci = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [TAG_W-1:0] out_tag;
    logic [CNT_W-1:0] out_count;

    int    n_check = 0;
    int    n_bad = 0;
    int    mx_cur = 20;
    int    exp_cnt [256];
    bit    pend [256];
    int    npend = 0;
    int    next_tag = 0;
    int    seq [2048];
    int    seq_n = 0;
    int    both_n = 0;
    int    cyc = 0;
    int    acc_cyc = 0;
    int    rdy_mode = 0;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hace1;
    bit    done_flag = 0;

    assign max_iter = CNT_W'(mx_cur);

    always #2 clk = ~clk;

    mandel_ring #(.DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .max_iter  (max_iter),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_cr     (in_cr),
        .in_ci     (in_ci),
        .in_tag    (in_tag),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_tag   (out_tag),
        .out_count (out_count)
    );

    // bit-exact model of the stated step and stop rules
    function automatic longint satv(input longint v);
        if (v > 131071) return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    function automatic int ref_cnt(input longint cr, input longint ci, input int mx);
        longint zr = 0;
        longint zi = 0;
        longint rr;
        longint ii;
        longint x;
        int n = 0;
        forever begin
            rr = (zr * zr) >>> 15;
            ii = (zi * zi) >>> 15;
            if (rr + ii > 131072) return n;
            if (n >= mx) return n;
            x  = (zr * zi) >>> 14;
            zr = satv(rr - ii + cr);
            zi = satv(x + ci);
            n++;
        end
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_check++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready = 1'b0;
            1: out_ready = 1'b1;
            default: out_ready = lfsr[0] | lfsr[3];
        endcase
    end

    // monitor: pops expected results by tag
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            chk(cur_req, "tag pending", pend[out_tag], 1);
            if (pend[out_tag]) begin
                chk(cur_req, "count", out_count, exp_cnt[out_tag]);
                pend[out_tag] = 0;
                npend--;
            end
            if (seq_n < 2048) begin
                seq[seq_n] = out_tag;
                seq_n++;
            end
        end
        if (rst_n && in_valid && in_ready && out_valid && out_ready) both_n++;
    end

    task automatic send(input int cr, input int ci);
        int t;
        t = next_tag;
        next_tag = (next_tag + 1) % 256;
        exp_cnt[t] = ref_cnt(cr, ci, mx_cur);
        pend[t] = 1;
        npend++;
        @(negedge clk);
        in_valid = 1'b1;
        in_cr = cr[DW-1:0];
        in_ci = ci[DW-1:0];
        in_tag = t[TAG_W-1:0];
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        acc_cyc = cyc;
    endtask

    task automatic stop_in();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int w = 0;
        while (npend != 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        #3;
        chk(req, "all results returned", npend, 0);
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", n_check, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_check++;
        n_bad++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

    initial begin
        int first_acc;
        int mark;
        int tag_slow;
        int tag_fast;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        cur_req = "R1";
        @(negedge clk);
        #1;
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "in_ready after reset", in_ready, 1);

        // R6: back-to-back fill; R9: full ring refuses input
        cur_req = "R6";
        rdy_mode = 1;
        mx_cur = 20;
        send(0, 0);
        first_acc = acc_cyc;
        for (int k = 1; k < DEPTH; k++) send(0, 0);
        chk("R6", "cycles for DEPTH accepts", acc_cyc - first_acc, DEPTH - 1);
        stop_in();
        #1;
        chk("R9", "in_ready with full busy ring", in_ready, 0);
        drain("R6");

        // R5: later fast point overtakes earlier slow point
        cur_req = "R5";
        mx_cur = 50;
        mark = seq_n;
        tag_slow = next_tag;
        send(0, 0);
        tag_fast = next_tag;
        send(98304, 98304);
        stop_in();
        drain("R5");
        chk("R5", "first returned tag", seq[mark], tag_fast);
        chk("R5", "second returned tag", seq[mark + 1], tag_slow);

        // R3: strict threshold
        cur_req = "R3";
        mx_cur = 30;
        chk("R3", "model count c=2.0", ref_cnt(65536, 0, 30), 2);
        chk("R3", "model count c=-2.0", ref_cnt(-65536, 0, 30), 30);
        send(65536, 0);
        send(-65536, 0);
        send(0, 32768);
        stop_in();
        drain("R3");

        // R2: grid with random output stalls, plus saturation corner
        cur_req = "R2";
        rdy_mode = 2;
        mx_cur = 40;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 6; j++) begin
                send(-80000 + i * 20000, -60000 + j * 24000);
            end
        end
        send(-131072, -131072);
        send(131071, 131071);
        stop_in();
        drain("R2");

        // R4: limit 0 and 1
        cur_req = "R4";
        rdy_mode = 1;
        mx_cur = 0;
        send(0, 0);
        send(98304, 98304);
        send(-40000, 20000);
        stop_in();
        drain("R4");
        mx_cur = 1;
        send(0, 0);
        send(98304, 98304);
        stop_in();
        drain("R4");

        // R8: finished points parked while output stalls
        cur_req = "R8";
        rdy_mode = 0;
        mx_cur = 5;
        for (int k = 0; k < DEPTH; k++) send(98304 - k * 1000, 98304);
        stop_in();
        repeat (40) @(negedge clk);
        #1;
        chk("R8", "results held while stalled", npend, DEPTH);
        chk("R8", "out_valid offered while stalled", out_valid, 1);
        chk("R9", "in_ready while full of parked points", in_ready, 0);
        rdy_mode = 1;
        drain("R8");

        // R7: retire and admit in the same cycle
        cur_req = "R7";
        mx_cur = 12;
        both_n = 0;
        for (int k = 0; k < 64; k++) begin
            send(-70000 + ((k * 7919) % 120000), -50000 + ((k * 3571) % 100000));
        end
        stop_in();
        drain("R7");
        chk("R7", "retire and admit together seen", both_n > 0, 1);

        finish_up();
    end

endmodule